// File: doc/BRIEF.md
# Five-Level Inverter Gate Sequencer

This block produces the six gate drives of a single-phase five-level inverter. The power stage has a dual-buck front end with two switches, called buck A and buck B here. Buck A draws on the first DC-link capacitor and buck B on the second. A full bridge follows the front end and unfolds its output. The block takes four digital samples: the signed utility voltage, the two capacitor voltages, and a threshold equal to half the DC link. It also takes a PWM duty reference and a dead-time length.

Once per carrier period the block makes two choices. It first decides whether the utility magnitude is above the half-link threshold. It then decides which capacitor is higher. From these two choices it picks one buck switch to modulate at carrier frequency. The other buck switch is held OFF in the low region and ON in the high region, so the higher capacitor is drained harder and the two stay balanced. The bridge runs at line frequency. It selects one diagonal pair per utility half-cycle and inserts a dead gap whenever it changes pair. A signed level output reports which of the five output levels the gate pattern applies.

Top module: `fl_gate_seq`

## Requirements
- R1: While rst_n is low, all six gates are OFF and level_o is 0. After reset is released, both buck gates and all bridge gates stay OFF until the first carrier period has sampled its inputs.
- R2: The carrier is a free-running counter with a period of 2^CNT_W clocks. A modulated buck gate is ON only in the cycles whose count is below the latched duty, so duty 0 keeps it OFF for the whole period. The duty, region, balance and polarity inputs are sampled only at the last count of a period and take effect from count 0 of the next period. Input changes in the middle of a period have no effect on that period.
- R3: Low region, where |grid_smp| is not greater than half_lvl. If cap_a_smp > cap_b_smp, buck A is modulated and buck B is OFF. If cap_b_smp > cap_a_smp, buck B is modulated and buck A is OFF.
- R4: High region, where |grid_smp| is greater than half_lvl (the most negative sample counts as magnitude 2^(SMP_W-1)). If cap_a_smp > cap_b_smp, buck B is modulated and buck A is held ON. If cap_b_smp > cap_a_smp, buck A is modulated and buck B is held ON.
- R5: When the two capacitor samples are equal, the balance choice of the previous period is kept. The choice after reset is "second capacitor higher".
- R6: A latched sample above zero selects the positive pair (br_pa_g and br_pb_g both ON). A latched sample below zero selects the negative pair (br_na_g and br_nb_g both ON). A zero sample keeps the latched polarity.
- R7: Any move onto a pair, including the first one after reset, starts one clock after the period begins. All four bridge gates are then OFF for dead_len+1 cycles, with dead_len sampled as the gap starts, and the new pair turns on in the cycle after. The two pairs are never ON together, and one pair never follows the other without a gap.
- R8: level_o, signed 3 bits, equals the number of buck gates ON multiplied by +1 with the positive pair ON, by −1 with the negative pair ON, and by 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grid_smp | input | SMP_W | Signed utility voltage sample |
| cap_a_smp | input | CAP_W | First capacitor voltage sample |
| cap_b_smp | input | CAP_W | Second capacitor voltage sample |
| half_lvl | input | SMP_W | Half-link threshold, unsigned |
| duty_ref | input | CNT_W | PWM duty in carrier counts |
| dead_len | input | DT_W | Bridge dead gap length minus one |
| buck_a_g | output | 1 | Gate of buck switch A |
| buck_b_g | output | 1 | Gate of buck switch B |
| br_pa_g | output | 1 | Positive diagonal, first switch |
| br_pb_g | output | 1 | Positive diagonal, second switch |
| br_na_g | output | 1 | Negative diagonal, first switch |
| br_nb_g | output | 1 | Negative diagonal, second switch |
| level_o | output | 3 | Signed applied level, −2..+2 |

## Verification
Each gate output is a direct function of registers, so any input sampled at the wrap edge shows up at count 0 of the next period. A bridge pair change is due at count 1, and the new pair arrives dead_len+1 cycles after that. The bench model updates on the same rising edge as the design, and every comparison takes place on the falling edge. Directed checks wait until the model's counter reaches the count under test, so each check lands in the exact cycle the requirements predict. Stimulus changes 1 ns after a falling edge, and none of the outputs depends combinationally on any input.

// File: rtl/fl_pkg.sv
package fl_pkg;

    typedef enum logic [1:0] {
        BR_IDLE = 2'd0,
        BR_DEAD = 2'd1,
        BR_POS  = 2'd2,
        BR_NEG  = 2'd3
    } br_state_e;

    typedef struct packed {
        logic a_on;
        logic b_on;
    } buck_gates_t;

endpackage

// File: rtl/fl_carrier.sv
module fl_carrier #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] CNT_LAST = '1;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + CNT_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == CNT_LAST);
endmodule

// File: rtl/fl_role_sel.sv
module fl_role_sel (
    input  logic                hi_rgn,
    input  logic                a_higher,
    input  logic                pwm,
    output fl_pkg::buck_gates_t gates
);
    // One switch chops; the other sits at the region's static level.
    always_comb begin
        if (hi_rgn) begin
            if (a_higher) begin
                gates.a_on = 1'b1;
                gates.b_on = pwm;
            end else begin
                gates.a_on = pwm;
                gates.b_on = 1'b1;
            end
        end else begin
            if (a_higher) begin
                gates.a_on = pwm;
                gates.b_on = 1'b0;
            end else begin
                gates.a_on = 1'b0;
                gates.b_on = pwm;
            end
        end
    end
endmodule

// File: rtl/fl_bridge_seq.sv
module fl_bridge_seq #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pol_vld,
    input  logic            pol_pos,
    input  logic [DT_W-1:0] dead_len,
    output logic            pa_g,
    output logic            pb_g,
    output logic            na_g,
    output logic            nb_g
);
    import fl_pkg::*;

    localparam logic [DT_W-1:0] DT_ONE = DT_W'(1);

    typedef struct packed {
        br_state_e       st;
        logic [DT_W-1:0] dt;
    } br_reg_t;

    br_reg_t br_d, br_q;

    always_comb begin
        br_d = br_q;
        case (br_q.st)
            BR_IDLE: begin
                if (pol_vld) begin
                    br_d.st = BR_DEAD;
                    br_d.dt = dead_len;
                end
            end
            BR_POS: begin
                if (!pol_pos) begin
                    br_d.st = BR_DEAD;
                    br_d.dt = dead_len;
                end
            end
            BR_NEG: begin
                if (pol_pos) begin
                    br_d.st = BR_DEAD;
                    br_d.dt = dead_len;
                end
            end
            BR_DEAD: begin
                if (br_q.dt == '0) br_d.st = pol_pos ? BR_POS : BR_NEG;
                else               br_d.dt = br_q.dt - DT_ONE;
            end
            default: br_d.st = BR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) br_q <= '{st: BR_IDLE, dt: '0};
        else        br_q <= br_d;
    end

    assign pa_g = (br_q.st == BR_POS);
    assign pb_g = (br_q.st == BR_POS);
    assign na_g = (br_q.st == BR_NEG);
    assign nb_g = (br_q.st == BR_NEG);
endmodule

// File: rtl/fl_level.sv
module fl_level (
    input  logic              a_on,
    input  logic              b_on,
    input  logic              pos_on,
    input  logic              neg_on,
    output logic signed [2:0] level
);
    logic [1:0] n_on;

    always_comb begin
        n_on = {1'b0, a_on} + {1'b0, b_on};
        if (pos_on)      level = $signed({1'b0, n_on});
        else if (neg_on) level = -$signed({1'b0, n_on});
        else             level = '0;
    end
endmodule

// File: rtl/fl_gate_seq.sv
module fl_gate_seq #(
    parameter int SMP_W = 12,
    parameter int CAP_W = 12,
    parameter int CNT_W = 6,
    parameter int DT_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [SMP_W-1:0] grid_smp,
    input  logic        [CAP_W-1:0] cap_a_smp,
    input  logic        [CAP_W-1:0] cap_b_smp,
    input  logic        [SMP_W-1:0] half_lvl,
    input  logic        [CNT_W-1:0] duty_ref,
    input  logic        [DT_W-1:0]  dead_len,
    output logic                    buck_a_g,
    output logic                    buck_b_g,
    output logic                    br_pa_g,
    output logic                    br_pb_g,
    output logic                    br_na_g,
    output logic                    br_nb_g,
    output logic signed [2:0]       level_o
);
    import fl_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] duty;
        logic             hi;
        logic             bal;
        logic             pol_pos;
        logic             pol_vld;
    } samp_t;

    samp_t            samp_d, samp_q;
    logic [CNT_W-1:0] carrier_cnt;
    logic             carrier_last;
    logic [SMP_W-1:0] grid_mag;
    logic             grid_zero;
    logic             pwm;
    logic             role_hi;
    logic             role_bal;
    buck_gates_t      buck;

    fl_carrier #(.CNT_W(CNT_W)) u_carrier (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_o  (carrier_cnt),
        .last_o (carrier_last)
    );

    // Magnitude as unsigned: the most negative code maps to 2^(SMP_W-1).
    always_comb begin
        if (grid_smp[SMP_W-1]) grid_mag = ~grid_smp + SMP_W'(1);
        else                   grid_mag = grid_smp;
        grid_zero = (grid_smp == '0);
    end

    // Period-boundary sampling of every role decision.
    always_comb begin
        samp_d = samp_q;
        if (carrier_last) begin
            samp_d.duty = duty_ref;
            samp_d.hi   = (grid_mag > half_lvl);
            if (cap_a_smp > cap_b_smp)      samp_d.bal = 1'b1;
            else if (cap_b_smp > cap_a_smp) samp_d.bal = 1'b0;
            if (!grid_zero) begin
                samp_d.pol_pos = ~grid_smp[SMP_W-1];
                samp_d.pol_vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) samp_q <= '0;
        else        samp_q <= samp_d;
    end

    assign pwm      = (carrier_cnt < samp_q.duty);
    assign role_hi  = samp_q.hi;
    assign role_bal = samp_q.bal;

    fl_role_sel u_role (
        .hi_rgn   (role_hi),
        .a_higher (role_bal),
        .pwm      (pwm),
        .gates    (buck)
    );

    fl_bridge_seq #(.DT_W(DT_W)) u_bridge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pol_vld  (samp_q.pol_vld),
        .pol_pos  (samp_q.pol_pos),
        .dead_len (dead_len),
        .pa_g     (br_pa_g),
        .pb_g     (br_pb_g),
        .na_g     (br_na_g),
        .nb_g     (br_nb_g)
    );

    assign buck_a_g = buck.a_on;
    assign buck_b_g = buck.b_on;

    fl_level u_level (
        .a_on   (buck.a_on),
        .b_on   (buck.b_on),
        .pos_on (br_pa_g),
        .neg_on (br_na_g),
        .level  (level_o)
    );
endmodule

// File: rtl/fl_gate_seq_chk.sv
module fl_gate_seq_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic             hi_q,
    input logic             bal_q,
    input logic             s_a,
    input logic             s_b,
    input logic             pa,
    input logic             pb,
    input logic             na,
    input logic             nb,
    input logic signed [2:0] level
);
    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!s_a && !s_b && !pa && !pb && !na && !nb && level == 3'sd0)
                else $error("gates active in reset"); // R1
        end
    end

    AST_ROLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> ($stable(hi_q) && $stable(bal_q))); // R2

    AST_LOW_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_q |-> !(s_a && s_b)); // R3

    AST_HIGH_ONE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        hi_q |-> (s_a || s_b)); // R4

    AST_PAIR_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        (pa == pb) && (na == nb)); // R6

    AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !((pa || pb) && (na || nb))); // R7

    AST_GAP_POS_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        pa |=> !na); // R7

    AST_GAP_NEG_POS: assert property (@(posedge clk) disable iff (!rst_n)
        na |=> !pa); // R7

    AST_LEVEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pa || na) |-> (level == 3'sd0)); // R8

    AST_LEVEL_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        pa |-> (level >= 3'sd0)); // R8
endmodule

bind fl_gate_seq fl_gate_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (carrier_cnt),
    .hi_q  (role_hi),
    .bal_q (role_bal),
    .s_a   (buck_a_g),
    .s_b   (buck_b_g),
    .pa    (br_pa_g),
    .pb    (br_pb_g),
    .na    (br_na_g),
    .nb    (br_nb_g),
    .level (level_o)
);

// File: tb/sim_fl_gate_seq.sv
`timescale 1ns/1ps
module sim_fl_gate_seq;
    localparam int SMP_W = 12;
    localparam int CAP_W = 12;
    localparam int CNT_W = 6;
    localparam int DT_W  = 4;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic signed [SMP_W-1:0] grid_smp = '0;
    logic        [CAP_W-1:0] cap_a_smp = '0;
    logic        [CAP_W-1:0] cap_b_smp = '0;
    logic        [SMP_W-1:0] half_lvl = '0;
    logic        [CNT_W-1:0] duty_ref = '0;
    logic        [DT_W-1:0]  dead_len = '0;
    logic buck_a_g, buck_b_g, br_pa_g, br_pb_g, br_na_g, br_nb_g;
    logic signed [2:0] level_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    fl_gate_seq #(.SMP_W(SMP_W), .CAP_W(CAP_W), .CNT_W(CNT_W), .DT_W(DT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .grid_smp(grid_smp), .cap_a_smp(cap_a_smp),
        .cap_b_smp(cap_b_smp), .half_lvl(half_lvl), .duty_ref(duty_ref),
        .dead_len(dead_len), .buck_a_g(buck_a_g), .buck_b_g(buck_b_g),
        .br_pa_g(br_pa_g), .br_pb_g(br_pb_g), .br_na_g(br_na_g), .br_nb_g(br_nb_g),
        .level_o(level_o)
    );

    // Behavioural reference: bridge 0 idle, 1 gap, 2 positive, 3 negative.
    int m_cnt, m_duty, m_hi, m_bal, m_pol, m_vld, m_br, m_dt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_duty = 0; m_hi = 0; m_bal = 0;
            m_pol = 0; m_vld = 0; m_br = 0; m_dt = 0;
        end else begin
            int g, mag;
            if (m_br == 0) begin
                if (m_vld != 0) begin m_br = 1; m_dt = int'(dead_len); end
            end else if (m_br == 2) begin
                if (m_pol == 0) begin m_br = 1; m_dt = int'(dead_len); end
            end else if (m_br == 3) begin
                if (m_pol == 1) begin m_br = 1; m_dt = int'(dead_len); end
            end else begin
                if (m_dt == 0) m_br = (m_pol == 1) ? 2 : 3;
                else           m_dt = m_dt - 1;
            end
            if (m_cnt == CMAX) begin
                g   = int'(grid_smp);
                mag = (g < 0) ? -g : g;
                m_duty = int'(duty_ref);
                m_hi   = (mag > int'(half_lvl)) ? 1 : 0;
                if (cap_a_smp > cap_b_smp)      m_bal = 1;
                else if (cap_b_smp > cap_a_smp) m_bal = 0;
                if (g > 0) begin m_pol = 1; m_vld = 1; end
                if (g < 0) begin m_pol = 0; m_vld = 1; end
            end
            m_cnt = (m_cnt + 1) % (CMAX + 1);
        end
    end

    function automatic logic [8:0] mk(input bit a, input bit b, input bit p, input bit n, input int lvl);
        logic [2:0] l3;
        l3 = 3'(lvl);
        return {a, b, p, p, n, n, l3};
    endfunction

    function automatic logic [8:0] dut_vec();
        return {buck_a_g, buck_b_g, br_pa_g, br_pb_g, br_na_g, br_nb_g, level_o};
    endfunction

    function automatic logic [8:0] model_vec();
        bit pwm, a, b, p, n;
        int cntv;
        if (!rst_n) return '0;
        pwm = (m_cnt < m_duty);
        if (m_hi != 0) begin
            if (m_bal != 0) begin a = 1; b = pwm; end
            else            begin a = pwm; b = 1; end
        end else begin
            if (m_bal != 0) begin a = pwm; b = 0; end
            else            begin a = 0; b = pwm; end
        end
        p = (m_br == 2);
        n = (m_br == 3);
        cntv = int'(a) + int'(b);
        return mk(a, b, p, n, p ? cntv : (n ? -cntv : 0));
    endfunction

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    // Every-cycle comparison against the reference.
    always @(negedge clk) begin
        if (!done) begin
            logic [8:0] e, d;
            string tag;
            e = model_vec();
            d = dut_vec();
            if (!rst_n)                 tag = "R1";
            else if (d[8:7] !== e[8:7]) tag = (m_hi != 0) ? "R4" : "R3";
            else if (d[6:3] !== e[6:3]) tag = "R7";
            else                        tag = "R8";
            chk(tag, d, e);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic set_in(input int g, input int h, input int a, input int b, input int d, input int dt);
        grid_smp  = SMP_W'(g);
        half_lvl  = SMP_W'(h);
        cap_a_smp = CAP_W'(a);
        cap_b_smp = CAP_W'(b);
        duty_ref  = CNT_W'(d);
        dead_len  = DT_W'(dt);
    endtask

    task automatic at_cnt(input int k);
        do @(negedge clk); while (m_cnt != k);
    endtask

    initial begin
        set_in(500, 1000, 1100, 1000, 20, 3);
        repeat (3) @(negedge clk);
        chk("R1 reset", dut_vec(), mk(0, 0, 0, 0, 0));
        #1 rst_n = 1'b1;
        at_cnt(3);
        chk("R1 idle after release", dut_vec(), mk(0, 0, 0, 0, 0));

        // low region, first capacitor higher
        at_cnt(0); at_cnt(0);
        at_cnt(5);  chk("R3 low A chops", dut_vec(), mk(1, 0, 1, 0, 1));
        at_cnt(25); chk("R2 above duty", dut_vec(), mk(0, 0, 1, 0, 0));
        #1 set_in(500, 1000, 1000, 1100, 20, 3);
        at_cnt(0);
        at_cnt(5);  chk("R3 low B chops", dut_vec(), mk(0, 1, 1, 0, 1));
        #1 set_in(500, 1000, 1000, 1000, 20, 3);
        at_cnt(0);
        at_cnt(5);  chk("R5 equal keeps B", dut_vec(), mk(0, 1, 1, 0, 1));

        // high region
        #1 set_in(1500, 1000, 1100, 1000, 20, 3);
        at_cnt(0);
        at_cnt(5);  chk("R4 high both on", dut_vec(), mk(1, 1, 1, 0, 2));
        at_cnt(30); chk("R4 high A held", dut_vec(), mk(1, 0, 1, 0, 1));
        #1 set_in(1500, 1000, 1000, 1100, 20, 3);
        at_cnt(0);
        at_cnt(30); chk("R4 high B held", dut_vec(), mk(0, 1, 1, 0, 1));

        // mid-period change is ignored until the boundary
        at_cnt(40);
        #1 set_in(500, 1000, 1100, 1000, 20, 3);
        at_cnt(50); chk("R2 mid-period ignored", dut_vec(), mk(0, 1, 1, 0, 1));
        at_cnt(5);  chk("R2 applied next period", dut_vec(), mk(1, 0, 1, 0, 1));

        // polarity reversal with a gap of 4 cycles
        #1 set_in(-500, 1000, 1100, 1000, 20, 3);
        at_cnt(0);  chk("R7 old pair at count 0", dut_vec(), mk(1, 0, 1, 0, 1));
        at_cnt(4);  chk("R7 gap end", dut_vec(), mk(1, 0, 0, 0, 0));
        at_cnt(5);  chk("R6 negative pair", dut_vec(), mk(1, 0, 0, 1, -1));
        #1 set_in(0, 1000, 1100, 1000, 20, 3);
        at_cnt(0);
        at_cnt(10); chk("R6 zero keeps polarity", dut_vec(), mk(1, 0, 0, 1, -1));

        // magnitude boundaries
        #1 set_in(-2048, 2047, 1100, 1000, 20, 3);
        at_cnt(0);
        at_cnt(30); chk("R4 most negative is high", dut_vec(), mk(1, 0, 0, 1, -1));
        #1 set_in(-1000, 1000, 1100, 1000, 20, 3);
        at_cnt(0);
        at_cnt(30); chk("R3 equal to threshold is low", dut_vec(), mk(0, 0, 0, 1, 0));

        // zero-length gap
        #1 set_in(500, 1000, 1100, 1000, 20, 0);
        at_cnt(0);
        at_cnt(1);  chk("R7 single gap cycle", dut_vec(), mk(1, 0, 0, 0, 0));
        at_cnt(2);  chk("R7 positive after gap", dut_vec(), mk(1, 0, 1, 0, 1));

        // duty extremes
        #1 set_in(500, 1000, 1100, 1000, 0, 0);
        at_cnt(0);
        at_cnt(5);  chk("R2 duty zero", dut_vec(), mk(0, 0, 1, 0, 0));
        #1 set_in(500, 1000, 1100, 1000, CMAX, 0);
        at_cnt(0);
        at_cnt(62); chk("R2 duty max on", dut_vec(), mk(1, 0, 1, 0, 1));
        at_cnt(63); chk("R2 duty max last off", dut_vec(), mk(0, 0, 1, 0, 0));

        // reset in mid-run
        at_cnt(20);
        #1 rst_n = 1'b0;
        @(negedge clk); chk("R1 reset mid-run", dut_vec(), mk(0, 0, 0, 0, 0));
        #1 rst_n = 1'b1;
        at_cnt(3);  chk("R1 idle after second release", dut_vec(), mk(0, 0, 0, 0, 0));
        at_cnt(10);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule